// File: doc/BRIEF.md
# Two-Bit Branch Predictor with Target Buffer

This unit sits beside the fetch stage and guesses, for each fetched address, whether the instruction there is a taken branch and where it goes. Direction comes from a history table of two-bit saturating counters, selected by low word-address bits of the PC. The destination comes from a direct-mapped target buffer that keeps a valid bit, an address tag and a target for each slot. A lookup is registered: the PC presented with `fetch_valid` in one cycle yields the prediction in the next. When the buffer hits and the counter says taken, `pred_redirect` rises together with `pred_target`, so the fetch logic can steer to the target without a bubble.

The stage that resolves branches reports each one on the update port. It gives the branch PC, the real outcome and the real target, plus what the front end actually did for that branch: whether it redirected and to which address. The unit trains the counter and refreshes the buffer. One cycle later it raises `flush` when the front end guessed wrong, so the pipeline control can discard younger work. Both tables are sized by parameters.

Top module: `bp_fetch_predictor`

## Requirements
- R1: After reset every counter holds 01 (weakly not-taken) and every buffer slot is invalid, so any lookup gives `pred_taken`=0, `pred_hit`=0 and `pred_redirect`=0.
- R2: A lookup with `fetch_valid`=1 in cycle N drives `pred_valid`=1 and its results in cycle N+1. `pred_valid` is 0 in a cycle after no lookup.
- R3: The counter index is PC[OFS_W+BHT_IDX_W-1:OFS_W], and the buffer index is PC[OFS_W+BTB_IDX_W-1:OFS_W]. The low OFS_W offset bits affect neither the index nor the tag.
- R4: Counter coding is 00 strong not-taken, 01 weak not-taken, 10 weak taken, 11 strong taken. Bit 1 is the predicted direction. A taken update adds one and a not-taken update subtracts one, saturating at 11 and at 00.
- R5: The predicted direction of a saturated counter changes only after two consecutive updates with the opposite outcome.
- R6: A buffer slot is written (valid set, tag and target stored) only by an update with outcome taken. The tag is PC[PC_W-1:OFS_W+BTB_IDX_W]. A not-taken update leaves the slot unchanged. A hit needs a valid slot whose tag matches.
- R7: `pred_redirect` is 1 exactly when `pred_hit` and `pred_taken` are both 1, and `pred_target` is the stored target of the hitting slot.
- R8: One cycle after an update, `flush` is 1 if the real outcome differs from the reported redirect, or if both are taken and the real target differs from the reported target. Otherwise `flush` is 0.
- R9: For a branch that is taken three times and then not taken, repeatedly, there is exactly one misprediction per round once the first round has trained it.
- R10: A lookup and an update to the same entry in the same cycle give the contents from before the update. The update is visible to the next lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_valid | input | 1 | Lookup request |
| fetch_pc | input | PC_W | Address being fetched |
| pred_valid | output | 1 | Prediction outputs hold a lookup result |
| pred_taken | output | 1 | Counter direction (counter bit 1) |
| pred_hit | output | 1 | Target buffer hit |
| pred_redirect | output | 1 | Steer fetch to `pred_target` |
| pred_target | output | PC_W | Stored target of the hitting slot |
| upd_valid | input | 1 | Resolved branch report |
| upd_pc | input | PC_W | Address of the resolved branch |
| upd_taken | input | 1 | Real outcome |
| upd_target | input | PC_W | Real target |
| upd_redirected | input | 1 | Front end redirected for this branch |
| upd_pred_target | input | PC_W | Target the front end used when it redirected |
| flush | output | 1 | Misprediction, one cycle after the update |

## Verification
The bench walks one counter through both saturation points. A counter that wrapped instead of saturating would flip direction after a single opposite outcome. Aliasing is tested with two PCs that share a buffer slot but carry different tags: a design that dropped the tag compare would redirect the second PC to the first one's target, and one that allocated on not-taken updates would show hits after a not-taken report. Flush is tested on all four direction combinations and on a wrong target, which catches a design that ignores target mismatch. A same-cycle lookup and update to one entry checks the read-before-write order, and a loop pattern checks that a trained branch costs exactly one miss per round.

// File: rtl/bp_pkg.sv
package bp_pkg;

  typedef logic [1:0] ctr_t;

  localparam ctr_t CTR_STRONG_NT = 2'b00;
  localparam ctr_t CTR_WEAK_NT   = 2'b01;
  localparam ctr_t CTR_WEAK_T    = 2'b10;
  localparam ctr_t CTR_STRONG_T  = 2'b11;

  // saturating step toward the resolved outcome
  function automatic ctr_t ctr_step(input ctr_t cur, input logic taken);
    ctr_t res;
    if (taken) res = (cur == CTR_STRONG_T)  ? cur : cur + 2'd1;
    else       res = (cur == CTR_STRONG_NT) ? cur : cur - 2'd1;
    return res;
  endfunction

  function automatic logic ctr_dir(input ctr_t cur);
    return cur[1];
  endfunction

endpackage

// File: rtl/bp_history_table.sv
module bp_history_table #(
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_idx,
  output bp_pkg::ctr_t     rd_ctr,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_taken
);
  import bp_pkg::*;

  localparam int DEPTH = 1 << IDX_W;

  ctr_t ctr_q [DEPTH];

  // training port; every entry restarts weakly not-taken
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) ctr_q[i] <= CTR_WEAK_NT;
    end else if (wr_en) begin
      ctr_q[wr_idx] <= ctr_step(ctr_q[wr_idx], wr_taken);
    end
  end

  // registered lookup, old contents on a same-entry collision
  always_ff @(posedge clk) begin
    if (rst)        rd_ctr <= CTR_WEAK_NT;
    else if (rd_en) rd_ctr <= ctr_q[rd_idx];
  end

  AST_CTR_SAT_HIGH: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_taken && ctr_q[wr_idx] == CTR_STRONG_T) |=> ctr_q[$past(wr_idx)] == CTR_STRONG_T); // R4
  AST_CTR_SAT_LOW: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_taken && ctr_q[wr_idx] == CTR_STRONG_NT) |=> ctr_q[$past(wr_idx)] == CTR_STRONG_NT); // R4
  AST_CTR_STEP_UP: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_taken && ctr_q[wr_idx] != CTR_STRONG_T) |=> ctr_q[$past(wr_idx)] == $past(ctr_q[wr_idx]) + 2'd1); // R5
  AST_CTR_STEP_DOWN: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_taken && ctr_q[wr_idx] != CTR_STRONG_NT) |=> ctr_q[$past(wr_idx)] == $past(ctr_q[wr_idx]) - 2'd1); // R5

endmodule

// File: rtl/bp_target_buffer.sv
module bp_target_buffer #(
  parameter int IDX_W = 4,
  parameter int TAG_W = 26,
  parameter int PC_W  = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic [TAG_W-1:0] rd_tag,
  output logic             rd_hit,
  output logic [PC_W-1:0]  rd_target,
  input  logic             upd_valid,
  input  logic             upd_taken,
  input  logic [IDX_W-1:0] upd_idx,
  input  logic [TAG_W-1:0] upd_tag,
  input  logic [PC_W-1:0]  upd_target
);
  localparam int DEPTH = 1 << IDX_W;

  // tag and target: plain arrays, no reset, one write and one read port
  logic [TAG_W-1:0] tag_mem [DEPTH];
  logic [PC_W-1:0]  tgt_mem [DEPTH];
  logic [DEPTH-1:0] valid_q;

  logic             wr_en;
  logic [TAG_W-1:0] rd_tag_mem;
  logic [TAG_W-1:0] rd_tag_req;
  logic             rd_valid;

  assign wr_en = upd_valid && upd_taken;

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_mem[upd_idx] <= upd_tag;
      tgt_mem[upd_idx] <= upd_target;
    end
    if (rd_en) begin
      rd_tag_mem <= tag_mem[rd_idx];
      rd_target  <= tgt_mem[rd_idx];
      rd_tag_req <= rd_tag;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q  <= '0;
      rd_valid <= 1'b0;
    end else begin
      if (wr_en)  valid_q[upd_idx] <= 1'b1;
      if (rd_en)  rd_valid <= valid_q[rd_idx];
    end
  end

  assign rd_hit = rd_valid && (rd_tag_mem == rd_tag_req);

  AST_BTB_NO_ALLOC_NT: assert property (@(posedge clk) disable iff (rst)
    (upd_valid && !upd_taken) |=> $stable(valid_q)); // R6
  AST_BTB_ALLOC_TAKEN: assert property (@(posedge clk) disable iff (rst)
    (upd_valid && upd_taken) |=> valid_q[$past(upd_idx)]); // R6

endmodule

// File: rtl/bp_resolve.sv
module bp_resolve #(
  parameter int PC_W = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            upd_valid,
  input  logic            upd_taken,
  input  logic            upd_redirected,
  input  logic [PC_W-1:0] upd_target,
  input  logic [PC_W-1:0] upd_pred_target,
  output logic            flush
);
  logic dir_wrong;
  logic tgt_wrong;

  assign dir_wrong = upd_taken != upd_redirected;
  assign tgt_wrong = upd_taken && upd_redirected && (upd_target != upd_pred_target);

  always_ff @(posedge clk) begin
    if (rst) flush <= 1'b0;
    else     flush <= upd_valid && (dir_wrong || tgt_wrong);
  end

  AST_FLUSH_ON_DIR_MISS: assert property (@(posedge clk) disable iff (rst)
    (upd_valid && (upd_taken != upd_redirected)) |=> flush); // R8
  AST_FLUSH_QUIET_WHEN_RIGHT: assert property (@(posedge clk) disable iff (rst)
    (upd_valid && upd_taken == upd_redirected && (!upd_taken || upd_target == upd_pred_target)) |=> !flush); // R8
  AST_FLUSH_NEEDS_UPDATE: assert property (@(posedge clk) disable iff (rst)
    !upd_valid |=> !flush); // R8

endmodule

// File: rtl/bp_fetch_predictor.sv
module bp_fetch_predictor #(
  parameter int PC_W      = 32,
  parameter int OFS_W     = 2,
  parameter int BHT_IDX_W = 6,
  parameter int BTB_IDX_W = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            fetch_valid,
  input  logic [PC_W-1:0] fetch_pc,
  output logic            pred_valid,
  output logic            pred_taken,
  output logic            pred_hit,
  output logic            pred_redirect,
  output logic [PC_W-1:0] pred_target,
  input  logic            upd_valid,
  input  logic [PC_W-1:0] upd_pc,
  input  logic            upd_taken,
  input  logic [PC_W-1:0] upd_target,
  input  logic            upd_redirected,
  input  logic [PC_W-1:0] upd_pred_target,
  output logic            flush
);
  import bp_pkg::*;

  localparam int TAG_LO = OFS_W + BTB_IDX_W;
  localparam int TAG_W  = PC_W - TAG_LO;

  logic [BHT_IDX_W-1:0] f_bht_idx, u_bht_idx;
  logic [BTB_IDX_W-1:0] f_btb_idx, u_btb_idx;
  logic [TAG_W-1:0]     f_tag, u_tag;
  ctr_t                 f_ctr;
  logic                 unused_ofs;

  assign f_bht_idx = fetch_pc[OFS_W +: BHT_IDX_W];
  assign u_bht_idx = upd_pc[OFS_W +: BHT_IDX_W];
  assign f_btb_idx = fetch_pc[OFS_W +: BTB_IDX_W];
  assign u_btb_idx = upd_pc[OFS_W +: BTB_IDX_W];
  assign f_tag     = fetch_pc[PC_W-1:TAG_LO];
  assign u_tag     = upd_pc[PC_W-1:TAG_LO];
  assign unused_ofs = ^{fetch_pc[OFS_W-1:0], upd_pc[OFS_W-1:0]};

  bp_history_table #(.IDX_W(BHT_IDX_W)) u_bht (
    .clk      (clk),
    .rst      (rst),
    .rd_en    (fetch_valid),
    .rd_idx   (f_bht_idx),
    .rd_ctr   (f_ctr),
    .wr_en    (upd_valid),
    .wr_idx   (u_bht_idx),
    .wr_taken (upd_taken)
  );

  bp_target_buffer #(.IDX_W(BTB_IDX_W), .TAG_W(TAG_W), .PC_W(PC_W)) u_btb (
    .clk        (clk),
    .rst        (rst),
    .rd_en      (fetch_valid),
    .rd_idx     (f_btb_idx),
    .rd_tag     (f_tag),
    .rd_hit     (pred_hit),
    .rd_target  (pred_target),
    .upd_valid  (upd_valid),
    .upd_taken  (upd_taken),
    .upd_idx    (u_btb_idx),
    .upd_tag    (u_tag),
    .upd_target (upd_target)
  );

  bp_resolve #(.PC_W(PC_W)) u_res (
    .clk             (clk),
    .rst             (rst),
    .upd_valid       (upd_valid),
    .upd_taken       (upd_taken),
    .upd_redirected  (upd_redirected),
    .upd_target      (upd_target),
    .upd_pred_target (upd_pred_target),
    .flush           (flush)
  );

  always_ff @(posedge clk) begin
    if (rst) pred_valid <= 1'b0;
    else     pred_valid <= fetch_valid;
  end

  assign pred_taken    = ctr_dir(f_ctr);
  assign pred_redirect = pred_hit && pred_taken;

  AST_PRED_LATENCY: assert property (@(posedge clk) disable iff (rst)
    fetch_valid |=> pred_valid); // R2
  AST_PRED_IDLE: assert property (@(posedge clk) disable iff (rst)
    !fetch_valid |=> !pred_valid); // R2

endmodule

// File: tb/bp_fetch_predictor_bench.sv
`timescale 1ns/1ps
module bp_fetch_predictor_bench;
  localparam int PC_W = 32;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            fetch_valid = 1'b0;
  logic [PC_W-1:0] fetch_pc = '0;
  logic            pred_valid, pred_taken, pred_hit, pred_redirect;
  logic [PC_W-1:0] pred_target;
  logic            upd_valid = 1'b0;
  logic [PC_W-1:0] upd_pc = '0;
  logic            upd_taken = 1'b0;
  logic [PC_W-1:0] upd_target = '0;
  logic            upd_redirected = 1'b0;
  logic [PC_W-1:0] upd_pred_target = '0;
  logic            flush;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic            lk_valid, lk_taken, lk_hit, lk_redir, uf;
  logic [PC_W-1:0] lk_tgt;

  always #2.5 clk = ~clk;

  bp_fetch_predictor u_bp_fetch_predictor (
    .clk(clk), .rst(rst), .fetch_valid(fetch_valid), .fetch_pc(fetch_pc),
    .pred_valid(pred_valid), .pred_taken(pred_taken), .pred_hit(pred_hit),
    .pred_redirect(pred_redirect), .pred_target(pred_target),
    .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken),
    .upd_target(upd_target), .upd_redirected(upd_redirected),
    .upd_pred_target(upd_pred_target), .flush(flush)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [PC_W-1:0] act, input logic [PC_W-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic lookup(input logic [PC_W-1:0] pc);
    @(negedge clk);
    fetch_valid = 1'b1; fetch_pc = pc;
    @(negedge clk);
    lk_valid = pred_valid; lk_taken = pred_taken; lk_hit = pred_hit;
    lk_redir = pred_redirect; lk_tgt = pred_target;
    fetch_valid = 1'b0;
    check(lk_valid === 1'b1, "R2", "pred_valid after lookup", {31'd0, lk_valid}, 1);
    check(lk_redir === (lk_hit && lk_taken), "R7", "redirect equals hit and taken",
          {31'd0, lk_redir}, {31'd0, lk_hit && lk_taken});
  endtask

  task automatic update(input logic [PC_W-1:0] pc, input logic tk, input logic [PC_W-1:0] tgt,
                        input logic redir, input logic [PC_W-1:0] ptgt);
    @(negedge clk);
    upd_valid = 1'b1; upd_pc = pc; upd_taken = tk; upd_target = tgt;
    upd_redirected = redir; upd_pred_target = ptgt;
    @(negedge clk);
    uf = flush;
    upd_valid = 1'b0;
  endtask

  task automatic expect_pred(input string req, input logic tk, input logic hit);
    check(lk_taken === tk, req, "pred_taken", {31'd0, lk_taken}, {31'd0, tk});
    check(lk_hit === hit, req, "pred_hit", {31'd0, lk_hit}, {31'd0, hit});
  endtask

  task automatic t_reset;
    lookup(32'h1000); expect_pred("R1", 1'b0, 1'b0);
    lookup(32'h1004); expect_pred("R1", 1'b0, 1'b0);
    @(negedge clk);
    check(pred_valid === 1'b0, "R2", "pred_valid idle", {31'd0, pred_valid}, 0);
  endtask

  task automatic t_offset;
    update(32'h1008, 1'b1, 32'h2000, 1'b0, 32'h0);
    lookup(32'h100A); // R3 offset bits differ from the trained PC
    expect_pred("R3", 1'b1, 1'b1);
    check(lk_tgt === 32'h2000, "R3", "target via offset-alias PC", lk_tgt, 32'h2000);
  endtask

  task automatic t_counter;
    logic [PC_W-1:0] pc = 32'h100C;
    update(pc, 1'b0, 0, 1'b0, 0);            // 01 -> 00
    lookup(pc); expect_pred("R4", 1'b0, 1'b0);
    update(pc, 1'b1, 32'h3000, 1'b0, 0);     // 00 -> 01
    lookup(pc); expect_pred("R5", 1'b0, 1'b1);
    update(pc, 1'b1, 32'h3000, 1'b0, 0);     // 01 -> 10
    lookup(pc); expect_pred("R4", 1'b1, 1'b1);
    check(lk_tgt === 32'h3000, "R7", "target", lk_tgt, 32'h3000);
    update(pc, 1'b1, 32'h3000, 1'b1, 32'h3000); // 11
    update(pc, 1'b1, 32'h3000, 1'b1, 32'h3000); // stays 11
    update(pc, 1'b0, 0, 1'b1, 32'h3000);        // 10
    lookup(pc); expect_pred("R5", 1'b1, 1'b1);  // one miss keeps direction
    update(pc, 1'b0, 0, 1'b1, 32'h3000);        // 01
    lookup(pc); expect_pred("R5", 1'b0, 1'b1);
    update(pc, 1'b0, 0, 1'b0, 0);               // 00
    update(pc, 1'b0, 0, 1'b0, 0);               // stays 00
    lookup(pc); expect_pred("R4", 1'b0, 1'b1);
    update(pc, 1'b1, 32'h3000, 1'b0, 0);        // 01
    lookup(pc); expect_pred("R5", 1'b0, 1'b1);
    update(pc, 1'b1, 32'h3000, 1'b0, 0);        // 10
    lookup(pc); expect_pred("R5", 1'b1, 1'b1);
  endtask

  task automatic t_buffer;
    update(32'h1010, 1'b1, 32'h5000, 1'b0, 0);
    lookup(32'h1010); expect_pred("R6", 1'b1, 1'b1);
    check(lk_tgt === 32'h5000, "R6", "stored target", lk_tgt, 32'h5000);
    lookup(32'h1050); expect_pred("R6", 1'b0, 1'b0); // same slot, other tag
    update(32'h1010, 1'b0, 32'hDEAD0000, 1'b1, 32'h5000);
    lookup(32'h1010); expect_pred("R6", 1'b0, 1'b1);
    check(lk_tgt === 32'h5000, "R6", "not-taken keeps target", lk_tgt, 32'h5000);
    check(lk_redir === 1'b0, "R7", "no redirect when not taken", {31'd0, lk_redir}, 0);
    update(32'h1010, 1'b1, 32'h6000, 1'b0, 0);
    lookup(32'h1010);
    check(lk_tgt === 32'h6000, "R6", "taken rewrites target", lk_tgt, 32'h6000);
    check(lk_redir === 1'b1, "R7", "redirect on hit and taken", {31'd0, lk_redir}, 1);
    update(32'h1014, 1'b0, 32'h7777, 1'b0, 0);
    lookup(32'h1014); expect_pred("R6", 1'b0, 1'b0); // no alloc on not-taken
    update(32'h1050, 1'b1, 32'h7000, 1'b0, 0);       // evicts the 0x1010 slot
    lookup(32'h1010);
    check(lk_hit === 1'b0, "R6", "evicted by other tag", {31'd0, lk_hit}, 0);
  endtask

  task automatic t_flush;
    update(32'h1018, 1'b1, 32'hA000, 1'b0, 0);
    check(uf === 1'b1, "R8", "taken but not redirected", {31'd0, uf}, 1);
    update(32'h1018, 1'b0, 32'hA000, 1'b1, 32'hA000);
    check(uf === 1'b1, "R8", "redirected but not taken", {31'd0, uf}, 1);
    update(32'h1018, 1'b1, 32'hA000, 1'b1, 32'hA000);
    check(uf === 1'b0, "R8", "correct taken", {31'd0, uf}, 0);
    update(32'h1018, 1'b1, 32'hA000, 1'b1, 32'hB000);
    check(uf === 1'b1, "R8", "wrong target", {31'd0, uf}, 1);
    update(32'h1018, 1'b0, 32'hC000, 1'b0, 32'hB000);
    check(uf === 1'b0, "R8", "correct not-taken", {31'd0, uf}, 0);
    @(negedge clk);
    check(flush === 1'b0, "R8", "no flush without update", {31'd0, flush}, 0);
  endtask

  task automatic t_collide;
    @(negedge clk);
    fetch_valid = 1'b1; fetch_pc = 32'h101C;
    upd_valid = 1'b1; upd_pc = 32'h101C; upd_taken = 1'b1; upd_target = 32'h9000;
    upd_redirected = 1'b0; upd_pred_target = 0;
    @(negedge clk);
    fetch_valid = 1'b0; upd_valid = 1'b0;
    check(pred_taken === 1'b0 && pred_hit === 1'b0, "R10", "same-cycle sees old entry",
          {30'd0, pred_taken, pred_hit}, 0);
    lookup(32'h101C); expect_pred("R10", 1'b1, 1'b1);
  endtask

  task automatic t_loop;
    int miss;
    for (int r = 0; r < 3; r++) begin
      miss = 0;
      for (int i = 0; i < 4; i++) begin
        lookup(32'h1020);
        update(32'h1020, i < 3, 32'h8000, lk_redir, lk_tgt);
        if (uf) miss++;
      end
      if (r > 0) check(miss == 1, "R9", "misses per loop round", miss, 1);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset;
    t_offset;
    t_counter;
    t_buffer;
    t_flush;
    t_collide;
    t_loop;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule